// File: doc/BRIEF.md
# Frame pixel CRC signature unit

This unit folds the stream of output pixels into a 32-bit CRC, one frame at a time, so that software can compare the display path against a known-good value. Each pixel is a 24-bit word qualified by a valid strobe. Frame boundaries are taken from the vertical sync signal: a capture always begins and ends on a high-to-low transition of `vsync`.

Software sets `sig_en` to arm the unit. The first falling `vsync` after that opens the capture. In single-frame mode the next falling `vsync` closes it and raises `done`. The unit then holds the result until software lowers `sig_en`, which clears the signature and returns the unit to rest. With `free_run` high, the capture spans frame after frame and `done` stays low. If `free_run` is lowered during such a capture, the accumulation stops at the end of the frame in progress.

Top module: `pixsig_top`

## Requirements
- R1: After reset, `signature` is 0 and `done` is 0.
- R2: While `sig_en` is 0, `signature` stays 0 and `done` stays 0, whatever happens on `vsync`, `pix_valid` and `pix_data`.
- R3: After `sig_en` is raised, pixels leave `signature` unchanged until the first cycle in which `vsync` is sampled low after being sampled high one cycle earlier. That falling-edge cycle is not itself captured.
- R4: During a capture, each clock with `pix_valid` high updates `signature` with CRC-32 (polynomial 0x04C11DB7, seed 0, no reflection, no final inversion), shifting in `pix_data` from bit 23 down to bit 0. The new value is visible after that clock edge.
- R5: During a capture, a clock with `pix_valid` low leaves `signature` unchanged.
- R6: With `free_run` low, the capture ends at the next falling `vsync`. `done` is 1 from the clock edge after that falling-edge cycle.
- R7: Once `done` is 1 and `sig_en` stays 1, `signature` and `done` hold through any further pixels and sync edges.
- R8: Lowering `sig_en` clears `signature` and `done` at the next clock edge. Raising it again arms a new capture.
- R9: With `free_run` high, falling `vsync` edges during a capture neither stop the accumulation nor raise `done`. The CRC runs on across the frames.
- R10: If `free_run` is lowered during a free-running capture, the accumulation stops at the next falling `vsync` and `done` is then raised, as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_data | input | 24 | Pixel word |
| pix_valid | input | 1 | Qualifies `pix_data` in this cycle |
| vsync | input | 1 | Vertical sync; falling edges bound the frames |
| sig_en | input | 1 | Arms the capture; low clears and holds the signature |
| free_run | input | 1 | Accumulate across frames instead of a single frame |
| signature | output | 32 | Current CRC accumulator |
| done | output | 1 | Single-frame capture complete |

## Verification
A sequencer in the wrong state shows up as a capture window shifted by a whole frame. Depending on the direction of the error, either `signature` moves while the unit should still be waiting for sync, or `done` rises one sync edge early or late. Both show on the ports within a cycle of the offending `vsync` fall. A fault in the CRC step or in the valid gating corrupts `signature` on the first pixel affected. Because the CRC carries the error forward, the wrong value is still visible in the final result. A clear path that fails to act leaves a nonzero value one cycle after `sig_en` drops.

// File: rtl/pixsig_pkg.sv
package pixsig_pkg;

    localparam int unsigned PIX_W   = 24;
    localparam int unsigned CRC_W   = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '0;

    typedef enum logic [1:0] {
        SG_IDLE  = 2'd0,
        SG_ARMED = 2'd1,
        SG_CAPT  = 2'd2,
        SG_DONE  = 2'd3
    } sig_state_e;

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] data;
    } pix_beat_t;

    // MSB-first CRC step over one pixel word
    function automatic logic [CRC_W-1:0] crc_advance(
        input logic [CRC_W-1:0] cur,
        input logic [PIX_W-1:0] word
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = cur;
        for (int i = PIX_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ word[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/pixsig_edge.sv
module pixsig_edge (
    input  logic clk,
    input  logic rst,
    input  logic vsync,
    output logic fall
);
    logic vs_q;

    always_ff @(posedge clk) begin
        if (rst) vs_q <= 1'b0;
        else     vs_q <= vsync;
    end

    assign fall = vs_q & ~vsync;
endmodule

// File: rtl/pixsig_ctrl.sv
module pixsig_ctrl
    import pixsig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       free_run,
    input  logic       fall,
    output sig_state_e state,
    output logic       capture,
    output logic       clear
);
    sig_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SG_IDLE:  nxt = SG_ARMED;
            SG_ARMED: if (fall) nxt = SG_CAPT;
            SG_CAPT:  if (fall && !free_run) nxt = SG_DONE;
            SG_DONE:  nxt = SG_DONE;
            default:  nxt = SG_IDLE;
        endcase
        if (!en) nxt = SG_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SG_IDLE;
        else     state <= nxt;
    end

    assign capture = (state == SG_CAPT);
    assign clear   = ~en;
endmodule

// File: rtl/pixsig_crc.sv
module pixsig_crc
    import pixsig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             capture,
    input  pix_beat_t        beat,
    output logic [CRC_W-1:0] sig
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            sig <= CRC_SEED;
        else if (capture && beat.valid)
            sig <= crc_advance(sig, beat.data);
    end
endmodule

// File: rtl/pixsig_top.sv
module pixsig_top
    import pixsig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_valid,
    input  logic             vsync,
    input  logic             sig_en,
    input  logic             free_run,
    output logic [CRC_W-1:0] signature,
    output logic             done
);
    logic       fall;
    logic       capture;
    logic       clear;
    sig_state_e state;
    pix_beat_t  beat;

    assign beat.valid = pix_valid;
    assign beat.data  = pix_data;

    pixsig_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .vsync (vsync),
        .fall  (fall)
    );

    pixsig_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (sig_en),
        .free_run (free_run),
        .fall     (fall),
        .state    (state),
        .capture  (capture),
        .clear    (clear)
    );

    pixsig_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .capture (capture),
        .beat    (beat),
        .sig     (signature)
    );

    assign done = (state == SG_DONE);
endmodule

// File: rtl/pixsig_chk.sv
module pixsig_chk (
    input logic        clk,
    input logic        rst,
    input logic        sig_en,
    input logic        free_run,
    input logic        vsync,
    input logic        pix_valid,
    input logic [31:0] signature,
    input logic        done
);
    a_r8_clear_when_off: assert property (@(posedge clk) disable iff (rst)
        !sig_en |=> (signature == 32'h0) && !done);

    a_r7_hold_after_done: assert property (@(posedge clk) disable iff (rst)
        done && sig_en |=> done && $stable(signature));

    a_r5_invalid_no_update: assert property (@(posedge clk) disable iff (rst)
        sig_en && !pix_valid |=> $stable(signature));

    a_r6_done_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !$past(vsync) && $past(vsync, 2));

    a_r9_free_run_no_done: assert property (@(posedge clk) disable iff (rst)
        !done && free_run |=> !done);
endmodule

bind pixsig_top pixsig_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sig_en    (sig_en),
    .free_run  (free_run),
    .vsync     (vsync),
    .pix_valid (pix_valid),
    .signature (signature),
    .done      (done)
);

// File: tb/test_pixsig_top.sv
module test_pixsig_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pix_data = '0;
    logic        pix_valid = 1'b0;
    logic        vsync = 1'b0;
    logic        sig_en = 1'b0;
    logic        free_run = 1'b0;
    logic [31:0] signature;
    logic        done;

    int checks = 0;
    int fails  = 0;
    logic [31:0] acc;
    logic [31:0] expq[$];
    logic        done_q = 1'b0;

    always #2 clk = ~clk;

    pixsig_top i_pixsig_top (
        .clk(clk), .rst(rst), .pix_data(pix_data), .pix_valid(pix_valid),
        .vsync(vsync), .sig_en(sig_en), .free_run(free_run),
        .signature(signature), .done(done)
    );

    function automatic logic [31:0] ref_step(logic [31:0] c, logic [23:0] d);
        logic [31:0] r = c;
        for (int k = 23; k >= 0; k--)
            r = (r[31] ^ d[k]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(logic vs, logic v, logic [23:0] d);
        @(negedge clk);
        vsync = vs; pix_valid = v; pix_data = d;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 24'h0);
    endtask

    // falling vsync: high one cycle, then low
    task automatic vs_fall();
        drive(1'b1, 1'b0, 24'h0);
        drive(1'b0, 1'b0, 24'h0);
        idle();
    endtask

    // pixels with every fifth one invalid (R5); acc tracks captured ones
    task automatic pixels(int n, logic [23:0] salt, bit cap);
        for (int i = 0; i < n; i++) begin
            logic        v = (i % 5) != 4;
            logic [23:0] d = salt ^ (24'(i) * 24'h01_0203);
            drive(1'b0, v, d);
            if (v && cap) acc = ref_step(acc, d);
        end
        idle();
    endtask

    // scoreboard monitor: pops an expected result when done rises
    always @(negedge clk) begin
        if (done && !done_q) begin
            if (expq.size() == 0) check("R6 unexpected done", 32'h1, 32'h0);
            else check("R6 frame result", signature, expq.pop_front());
        end
        done_q <= done;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        check("R1 reset signature", signature, 32'h0);
        check("R1 reset done", {31'h0, done}, 32'h0);

        // R2: disabled unit ignores everything
        vs_fall();
        pixels(12, 24'h123456, 1'b0);
        vs_fall();
        check("R2 disabled signature", signature, 32'h0);
        check("R2 disabled done", {31'h0, done}, 32'h0);

        // R3: armed, no capture before the falling edge
        @(negedge clk); sig_en = 1'b1;
        pixels(10, 24'hABCDEF, 1'b0);
        check("R3 armed no capture", signature, 32'h0);

        // single frame: R4, R5, R6
        vs_fall();
        acc = 32'h0;
        pixels(20, 24'h5A3C96, 1'b1);
        check("R4 R5 running CRC", signature, acc);
        check("R6 not done mid-frame", {31'h0, done}, 32'h0);
        expq.push_back(acc);
        vs_fall();
        check("R6 done after end edge", {31'h0, done}, 32'h1);
        check("R6 final signature", signature, acc);

        // R7: hold after done
        pixels(8, 24'h0F0F0F, 1'b0);
        vs_fall();
        check("R7 hold signature", signature, acc);
        check("R7 hold done", {31'h0, done}, 32'h1);

        // R8: clearing enable
        @(negedge clk); sig_en = 1'b0;
        idle();
        check("R8 cleared signature", signature, 32'h0);
        check("R8 cleared done", {31'h0, done}, 32'h0);

        // R8 re-arm, R9 free run
        @(negedge clk); sig_en = 1'b1; free_run = 1'b1;
        idle();
        vs_fall();
        acc = 32'h0;
        pixels(15, 24'h777000, 1'b1);
        vs_fall();
        check("R9 no done at frame edge", {31'h0, done}, 32'h0);
        pixels(15, 24'h00ABCD, 1'b1);
        vs_fall();
        check("R9 accumulates two frames", signature, acc);
        check("R9 still not done", {31'h0, done}, 32'h0);

        // R10: drop free run mid-frame, stops at end of this frame
        pixels(6, 24'h31337A, 1'b1);
        @(negedge clk); free_run = 1'b0;
        pixels(6, 24'hC0FFEE, 1'b1);
        expq.push_back(acc);
        vs_fall();
        check("R10 done at frame end", {31'h0, done}, 32'h1);
        check("R10 signature", signature, acc);
        pixels(5, 24'h999999, 1'b0);
        check("R10 stopped after end", signature, acc);

        idle();
        check("R6 scoreboard drained", 32'(expq.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule